// File: doc/BRIEF.md
# Stochastic Hyperbolic Tangent Unit

This block applies a hyperbolic tangent activation to a bipolar stochastic bit-stream. A value x in [-1, 1] travels as a serial stream in which the fraction of ones is (x+1)/2. The unit holds a saturating up/down state of K positions, with K even. Each enabled cycle it takes one stream bit. A one moves the state up by one and a zero moves it down by one. The output bit is a pure decode of the current state. Over a long stream the fraction of ones in the output approximates the bipolar encoding of tanh((K/2)·x).

A build-time switch selects where the output threshold sits. The balanced variant splits the states in half. The skewed variant drives 0 only in the bottom fifth of the states. The skewed split counteracts the under-counting that an approximate max-pooling stage placed upstream introduces. The state count K is a parameter chosen by the integrator from the stream length and the fan-in. The unit itself does not derive it. Clearing `step_en` freezes the unit, so a stalled upstream stage inserts no bits.

Top module: `stanh_fsm`

## Requirements
- R1: After reset the state is K/2. With the balanced split (K=16) and with the skewed split (K=10), `stream_out` reads 1 right after reset.
- R2: On a cycle with `step_en`=1 and `stream_in`=1, the state rises by one. When the state is below K−1, the next state is the current state plus one.
- R3: On a cycle with `step_en`=1 and `stream_in`=0, the state falls by one. When the state is above 0, the next state is the current state minus one.
- R4: A one arriving while the state is at K−1 leaves it at K−1. There is no wraparound.
- R5: A zero arriving while the state is at 0 leaves it at 0. There is no wraparound.
- R6: With the balanced split (SKEWED=0), `stream_out` is 0 when the state is below K/2 and 1 otherwise.
- R7: With the skewed split (SKEWED=1), `stream_out` is 0 when the state is below floor(K/5) and 1 otherwise.
- R8: While `step_en`=0, the state does not change, whatever `stream_in` carries. `stream_out` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to the middle state |
| step_en | input | 1 | Consume `stream_in` this cycle when 1; freeze when 0 |
| stream_in | input | 1 | Bipolar stochastic input bit |
| stream_out | output | 1 | Bipolar stochastic output bit, decoded from the current state |

## Verification
A single zero after reset separates a correct middle start from an off-by-one start. With the balanced split, that zero must turn the output to 0 at once. Long runs of ones and of zeros push the state into each end. A fixed number of opposite bits then has to cross the threshold on exactly the cycle a saturating counter predicts, which exposes wraparound or a wrong end value. The balanced instance (K=16) and the skewed instance (K=10) get the same stimulus, so a threshold placed at the wrong state shows up as an output mismatch on the crossing cycle. Pseudo-random streams of several densities, interleaved with disabled cycles that carry arbitrary bits, exercise the freeze behaviour and the mid-range stepping against the bench's own model on every clock.

// File: rtl/stanh_pkg.sv
package stanh_pkg;

  // Saturating one-step move within 0 .. k-1.
  function automatic int stanh_next(input int s, input logic up, input int k);
    if (up) return (s >= k - 1) ? k - 1 : s + 1;
    else    return (s <= 0)     ? 0     : s - 1;
  endfunction

  // First state index that decodes to an output of 1.
  function automatic int stanh_thresh(input int k, input bit skewed);
    return skewed ? (k / 5) : (k / 2);
  endfunction

  function automatic int stanh_mid(input int k);
    return k / 2;
  endfunction

endpackage

// File: rtl/stanh_step.sv
module stanh_step #(
  parameter int K_STATES = 16,
  parameter int ST_W     = $clog2(K_STATES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  input  logic            up,
  output logic [ST_W-1:0] state
);
  import stanh_pkg::*;

  localparam logic [ST_W-1:0] TOP_ST = ST_W'(K_STATES - 1);
  localparam logic [ST_W-1:0] MID_ST = ST_W'(stanh_mid(K_STATES));

  logic [ST_W-1:0] state_d;
  logic            at_top;
  logic            at_bottom;

  assign at_top    = (state == TOP_ST);
  assign at_bottom = (state == '0);

  always_comb begin
    state_d = state;
    if (step_en) state_d = ST_W'(stanh_next(int'(state), up, K_STATES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= MID_ST;
    else        state <= state_d;
  end

  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && up && !at_top) |=> (state == ST_W'($past(state) + 1'b1)));

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !up && !at_bottom) |=> (state == ST_W'($past(state) - 1'b1)));

  p_sat_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && up && at_top) |=> (state == TOP_ST));

  p_sat_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !up && at_bottom) |=> (state == '0));

  p_state_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(state));

endmodule

// File: rtl/stanh_decide.sv
module stanh_decide #(
  parameter int K_STATES = 16,
  parameter bit SKEWED   = 1'b0,
  parameter int ST_W     = $clog2(K_STATES)
) (
  input  logic [ST_W-1:0] state,
  output logic            bit_out
);
  import stanh_pkg::*;

  generate
    if (SKEWED) begin : g_skew
      localparam logic [ST_W-1:0] LOW_BAND = ST_W'(stanh_thresh(K_STATES, 1'b1));
      assign bit_out = (state >= LOW_BAND);
    end else begin : g_half
      localparam logic [ST_W-1:0] HALF_PT = ST_W'(stanh_thresh(K_STATES, 1'b0));
      assign bit_out = (state >= HALF_PT);
    end
  endgenerate

endmodule

// File: rtl/stanh_fsm.sv
module stanh_fsm #(
  parameter int K_STATES = 16,
  parameter bit SKEWED   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic stream_in,
  output logic stream_out
);
  localparam int ST_W = $clog2(K_STATES);

  logic [ST_W-1:0] cur_state;

  stanh_step #(.K_STATES(K_STATES), .ST_W(ST_W)) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (step_en),
    .up      (stream_in),
    .state   (cur_state)
  );

  stanh_decide #(.K_STATES(K_STATES), .SKEWED(SKEWED), .ST_W(ST_W)) u_decide (
    .state   (cur_state),
    .bit_out (stream_out)
  );

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(stream_out));

  p_rise_needs_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stream_out && !(step_en && stream_in)) |=> !stream_out);

  p_fall_needs_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_out && !(step_en && !stream_in)) |=> stream_out);

endmodule

// File: tb/stanh_fsm_test.sv
`timescale 1ns/1ps
module stanh_fsm_test;
  localparam int KH = 16;
  localparam int KS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic din = 1'b0;
  logic out_h, out_s;

  int checks = 0;
  int errors = 0;
  int mh, ms;          // model states
  bit done = 1'b0;
  int unsigned lfsr = 32'hACE1_1234;

  always #4 clk = ~clk;

  stanh_fsm #(.K_STATES(KH), .SKEWED(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .step_en(en), .stream_in(din), .stream_out(out_h));

  stanh_fsm #(.K_STATES(KS), .SKEWED(1'b1)) uut_skew (
    .clk(clk), .rst_n(rst_n), .step_en(en), .stream_in(din), .stream_out(out_s));

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string move_tag(input bit e, input bit b, input int s, input int k);
    if (!e) return "R8";
    if (b && s == k - 1) return "R4";
    if (!b && s == 0) return "R5";
    return b ? "R2" : "R3";
  endfunction

  function automatic int model_move(input int s, input bit b, input int k);
    int n;
    n = b ? s + 1 : s - 1;
    if (n > k - 1) n = k - 1;
    if (n < 0) n = 0;
    return n;
  endfunction

  task automatic step(input bit e, input bit b);
    string th, ts;
    @(negedge clk);
    en = e; din = b;
    @(posedge clk);
    #1;
    th = move_tag(e, b, mh, KH);
    ts = move_tag(e, b, ms, KS);
    if (e) begin
      mh = model_move(mh, b, KH);
      ms = model_move(ms, b, KS);
    end
    check({"R6 ", th}, out_h, (mh >= KH / 2));
    check({"R7 ", ts}, out_s, (ms >= KS / 5));
  endtask

  function automatic bit next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return 1'b1;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit dummy;
    mh = KH / 2;
    ms = KS / 2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: middle start decodes to 1 in both variants
    check("R1 balanced", out_h, 1'b1);
    check("R1 skewed", out_s, 1'b1);

    // R6 boundary: one zero from K/2 reaches K/2-1
    step(1'b1, 1'b0);
    check("R6 crossing", out_h, 1'b0);
    step(1'b1, 1'b1);

    // R4: saturate high, then exact crossing count
    for (int i = 0; i < 24; i++) step(1'b1, 1'b1);
    for (int i = 0; i < KH / 2; i++) step(1'b1, 1'b0);
    check("R4 sat-high crossing", out_h, 1'b0);

    // R5: saturate low, then climb through the skewed threshold
    for (int i = 0; i < 24; i++) step(1'b1, 1'b0);
    check("R5 floor", out_s, 1'b0);
    step(1'b1, 1'b1);
    check("R7 below band", out_s, 1'b0);
    step(1'b1, 1'b1);
    check("R7 at band", out_s, 1'b1);

    // R8: disabled cycles with arbitrary bits
    for (int i = 0; i < 12; i++) step(1'b0, i[0] ^ i[2]);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0);

    // Alternating pattern around the middle
    for (int i = 0; i < 40; i++) step(1'b1, i[0]);

    // Pseudo-random streams of several densities with random stalls
    for (int d = 0; d < 4; d++) begin
      for (int i = 0; i < 1500; i++) begin
        bit e, b;
        dummy = next_rand();
        e = (lfsr[7:5] != 3'd0);
        case (d)
          0: b = (lfsr[1:0] != 2'd0);
          1: b = (lfsr[1:0] == 2'd0);
          2: b = lfsr[3];
          default: b = (lfsr[2:0] != 3'd0);
        endcase
        step(e, b);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule